// File: doc/BRIEF.md
# Stream Transmit Packet Queue

A register-mapped peripheral that lets a processor build outbound packets one 32-bit word at a time and hands each finished packet to a stream master port. Software writes payload words to a data register. The words stay queued and invisible on the stream side until software writes the packet's byte count to a length register. That length write marks the packet as complete and releases it. The stream port then presents the words in order and flags the final word of each packet with tlast.

Free space is reported through a vacancy register. The reported space is capped four words below the physical depth, and data writes beyond that cap are refused. Sticky status bits record the following events:
- a completed transmission
- a refused (overrun) word
- a byte count that disagrees with the number of words written
- the completion of a keyed flush

A flush empties everything, whether committed or not, but only when the exact key value is written.

Top module: `tx_stream_pktq`

## Requirements
- R1: After rst_ni is released, m_tvalid_o is 0, the status word (offset 0x00) reads 0 and the vacancy (offset 0x0C) reads DEPTH-4 (12 by default).
- R2: A write to offset 0x10 queues its data as one word; queued words do not appear on the stream (m_tvalid_o stays 0) until a byte length is written to offset 0x14.
- R3: Committed words leave in write order, one per cycle in which m_tvalid_o and m_tready_i are both 1; m_tlast_o is 1 exactly on the last word of each packet; while m_tready_i is 0 the presented word and tlast hold.
- R4: Vacancy at offset 0x0C reads (DEPTH-4) minus the number of words held, committed or not, and rises as words drain from the stream.
- R5: A data write while vacancy is 0 is dropped and sets status bit 28 (overrun); the dropped word is never sent.
- R6: Status bit 27 (transmit complete) sets after the final word of a packet is accepted on the stream.
- R7: A length write whose value is not 4 times the number of words written since the previous length write sets status bit 25 (length mismatch); the packet is still sent with the words actually written.
- R8: Writing 0xA5 to offset 0x08 discards all committed and uncommitted words, drops m_tvalid_o, restores vacancy to DEPTH-4 and sets status bit 24 (flush complete).
- R9: Writing any other value to offset 0x08 changes nothing: vacancy, status and queued packets are unaffected.
- R10: Writing offset 0x00 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R11: Several committed packets queue back to back, each ending with its own tlast, and are sent in commit order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| m_tdata_o | output | 32 | Stream data |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready |
| m_tlast_o | output | 1 | Last word of packet |

## Verification
A wrong occupancy count shows up in the vacancy register on the register read that follows the write, one cycle later. It also shows up as a refused or wrongly accepted word at the overrun boundary. A wrong packet-length entry or a wrong in-packet counter moves tlast to the wrong word, and the drain check of that packet's word-by-word comparison catches it. A flush or status bit that fails to set or clear is visible on the status read in the very next cycle. Back-to-back packets and a drained queue expose any pointer that has slipped, because every word carries a packet-unique value.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
  localparam logic [5:0] OFF_STAT  = 6'h00;
  localparam logic [5:0] OFF_FLUSH = 6'h08;
  localparam logic [5:0] OFF_VAC   = 6'h0C;
  localparam logic [5:0] OFF_DATA  = 6'h10;
  localparam logic [5:0] OFF_LEN   = 6'h14;
  localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;
  localparam int BIT_OVR  = 28;
  localparam int BIT_TC   = 27;
  localparam int BIT_MIS  = 25;
  localparam int BIT_RSTC = 24;
  typedef struct packed {
    logic ovr;
    logic tc;
    logic mis;
    logic rstc;
  } tpq_evt_t;
endpackage

// File: rtl/tpq_word_ram.sv
module tpq_word_ram #(
  parameter int DEPTH  = 16,
  parameter int USABLE = 12,
  parameter int DW     = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic [CW-1:0] occ_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_o    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_o    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      occ_o <= occ_o + CW'(push_i) - CW'(pop_i);
    end
  end

  assign pop_data_o = mem_q[rd_ptr_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_o <= CW'(USABLE)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> occ_o != '0); // R3
endmodule

// File: rtl/tpq_len_q.sv
module tpq_len_q #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [CW-1:0] push_cnt_i,
  input  logic          pop_i,
  output logic [CW-1:0] head_o,
  output logic          avail_o
);
  logic [CW-1:0] cnt_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] fill_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) cnt_q[wr_q] <= push_cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; fill_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0; rd_q <= '0; fill_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      fill_q <= fill_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = cnt_q[rd_q];
  assign avail_o = fill_q != '0;

  AST_LENQ_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> fill_q < CW'(DEPTH)); // R11
  AST_LENQ_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> push_cnt_i != '0); // R2
endmodule

// File: rtl/tpq_stat.sv
module tpq_stat
  import tpq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  tpq_evt_t set_i,
  input  logic     clr_we_i,
  input  tpq_evt_t clr_i,
  output tpq_evt_t stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~(clr_we_i ? clr_i : '0)) | set_i;
  end

  AST_CLR_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && clr_i == '0 |=> (stat_o & $past(stat_o)) == $past(stat_o)); // R10
endmodule

// File: rtl/tx_stream_pktq.sv
module tx_stream_pktq
  import tpq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int HOLD_BACK = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [31:0] m_tdata_o,
  output logic        m_tvalid_o,
  input  logic        m_tready_i,
  output logic        m_tlast_o
);
  localparam int USABLE = DEPTH - HOLD_BACK;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] USABLE_C = CW'(USABLE);

  logic          wr_data, wr_len, wr_flush, wr_stat;
  logic          room, push, commit, pkt_push, hs, pkt_pop;
  logic [CW-1:0] occ, pend_q, sent_q, head;
  logic          avail;
  logic [31:0]   exp_bytes, vacancy, stat_word;
  tpq_evt_t      evt, clr, stat;

  assign wr_data  = reg_wr_i && reg_addr_i == OFF_DATA;
  assign wr_len   = reg_wr_i && reg_addr_i == OFF_LEN;
  assign wr_stat  = reg_wr_i && reg_addr_i == OFF_STAT;
  assign wr_flush = reg_wr_i && reg_addr_i == OFF_FLUSH && reg_wdata_i == FLUSH_KEY;

  assign room     = occ < USABLE_C;
  assign push     = wr_data && room;
  assign commit   = wr_len;
  assign pkt_push = commit && pend_q != '0;
  assign exp_bytes = {{(30-CW){1'b0}}, pend_q, 2'b00};

  // words written since the last commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= '0;
    else if (wr_flush) pend_q <= '0;
    else if (commit)   pend_q <= '0;
    else if (push)     pend_q <= pend_q + CW'(1);
  end

  tpq_word_ram #(.DEPTH(DEPTH), .USABLE(USABLE), .DW(32)) u_ram (
    .clk_i, .rst_ni,
    .flush_i    (wr_flush),
    .push_i     (push),
    .push_data_i(reg_wdata_i),
    .pop_i      (hs),
    .pop_data_o (m_tdata_o),
    .occ_o      (occ)
  );

  tpq_len_q #(.DEPTH(DEPTH)) u_lenq (
    .clk_i, .rst_ni,
    .flush_i   (wr_flush),
    .push_i    (pkt_push),
    .push_cnt_i(pend_q),
    .pop_i     (pkt_pop),
    .head_o    (head),
    .avail_o   (avail)
  );

  assign m_tvalid_o = avail;
  assign m_tlast_o  = avail && (sent_q + CW'(1) == head);
  assign hs         = m_tvalid_o && m_tready_i;
  assign pkt_pop    = hs && m_tlast_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sent_q <= '0;
    else if (wr_flush) sent_q <= '0;
    else if (pkt_pop)  sent_q <= '0;
    else if (hs)       sent_q <= sent_q + CW'(1);
  end

  always_comb begin
    evt.ovr  = wr_data && !room;
    evt.tc   = pkt_pop;
    evt.mis  = commit && reg_wdata_i != exp_bytes;
    evt.rstc = wr_flush;
    clr.ovr  = reg_wdata_i[BIT_OVR];
    clr.tc   = reg_wdata_i[BIT_TC];
    clr.mis  = reg_wdata_i[BIT_MIS];
    clr.rstc = reg_wdata_i[BIT_RSTC];
  end

  tpq_stat u_stat (
    .clk_i, .rst_ni,
    .set_i   (evt),
    .clr_we_i(wr_stat),
    .clr_i   (clr),
    .stat_o  (stat)
  );

  assign vacancy = 32'(USABLE_C - occ);

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_OVR]  = stat.ovr;
    stat_word[BIT_TC]   = stat.tc;
    stat_word[BIT_MIS]  = stat.mis;
    stat_word[BIT_RSTC] = stat.rstc;
    unique case (reg_addr_i)
      OFF_STAT: reg_rdata_o = stat_word;
      OFF_VAC:  reg_rdata_o = vacancy;
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i && !wr_flush |=>
      m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)); // R3
  AST_VAC_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vacancy <= 32'(USABLE)); // R4
  AST_OVR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && occ == USABLE_C |=> stat.ovr && occ == $past(occ) - CW'($past(hs))); // R5
  AST_TC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && m_tlast_o |=> stat.tc); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flush |=> !m_tvalid_o && occ == '0 && stat.rstc); // R8
  AST_HIDDEN_UNTIL_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_tvalid_o && !pkt_push |=> !m_tvalid_o); // R2
endmodule

// File: tb/tx_stream_pktq_tb.sv
module tx_stream_pktq_tb;
  import tpq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] m_tdata;
  logic        m_tvalid, m_tlast;
  logic        m_tready = 1'b0;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tx_stream_pktq u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .m_tdata_o(m_tdata), .m_tvalid_o(m_tvalid), .m_tready_i(m_tready),
    .m_tlast_o(m_tlast)
  );

  // {words, byte length, ready pattern}
  localparam logic [23:0] VEC [5] = '{
    24'h03_0C_FF, 24'h05_14_B2, 24'h01_04_55, 24'h04_0C_FF, 24'h0C_30_C3
  };
  localparam int USABLE = 12;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push_words(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) wr(OFF_DATA, base + 32'(i));
  endtask

  task automatic drain(input string req, input int n, input logic [31:0] base,
                       input logic [7:0] pat);
    int idx = 0;
    int cyc = 0;
    while (idx < n && cyc < 400) begin
      @(negedge clk);
      m_tready = pat[cyc % 8];
      #1;
      if (m_tvalid && m_tready) begin
        chk(req, "tdata", m_tdata, base + 32'(idx));
        chk(req, "tlast", 32'(m_tlast), 32'(idx == n - 1));
        idx++;
      end
      cyc++;
    end
    @(negedge clk);
    m_tready = 1'b0;
    chk(req, "words drained", 32'(idx), 32'(n));
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "tvalid", 32'(m_tvalid), 0);
    rd(OFF_STAT, r); chk("R1", "status", r, 0);
    rd(OFF_VAC, r);  chk("R1", "vacancy", r, USABLE);

    // table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < 5; v++) begin
      int n;
      logic [31:0] len, base, exp_st;
      n    = int'(VEC[v][23:16]);
      len  = 32'(VEC[v][15:8]);
      base = {8'(v + 1), 24'h0};
      wr(OFF_STAT, 32'hFFFF_FFFF);
      push_words(n, base);
      rd(OFF_VAC, r); chk("R4", "vacancy before commit", r, 32'(USABLE - n));
      repeat (2) @(negedge clk);
      chk("R2", "tvalid before commit", 32'(m_tvalid), 0);
      wr(OFF_LEN, len);
      drain("R3", n, base, VEC[v][7:0]);
      chk("R3", "tvalid after drain", 32'(m_tvalid), 0);
      exp_st = (32'h1 << BIT_TC) | ((len != 32'(4 * n)) ? (32'h1 << BIT_MIS) : 32'h0);
      rd(OFF_STAT, r); chk("R6_R7", "status after packet", r, exp_st);
      rd(OFF_VAC, r);  chk("R4", "vacancy after drain", r, USABLE);
    end

    // R5 overrun
    wr(OFF_STAT, 32'hFFFF_FFFF);
    push_words(USABLE, 32'hA000_0000);
    rd(OFF_VAC, r); chk("R5", "vacancy full", r, 0);
    wr(OFF_DATA, 32'hDEAD_BEEF);
    rd(OFF_STAT, r); chk("R5", "overrun bit", r, 32'h1 << BIT_OVR);
    rd(OFF_VAC, r);  chk("R5", "vacancy still 0", r, 0);
    wr(OFF_LEN, 32'(4 * USABLE));
    drain("R5", USABLE, 32'hA000_0000, 8'hFF);
    chk("R5", "no dropped word sent", 32'(m_tvalid), 0);

    // R9 wrong key ignored
    wr(OFF_STAT, 32'hFFFF_FFFF);
    push_words(2, 32'hB000_0000);
    wr(OFF_FLUSH, 32'h0000_005A);
    rd(OFF_VAC, r);  chk("R9", "vacancy kept", r, USABLE - 2);
    rd(OFF_STAT, r); chk("R9", "status unchanged", r, 0);
    wr(OFF_LEN, 32'd8);
    drain("R9", 2, 32'hB000_0000, 8'hFF);

    // R8 keyed flush of committed and pending words
    wr(OFF_STAT, 32'hFFFF_FFFF);
    push_words(3, 32'hC000_0000);
    wr(OFF_LEN, 32'd12);
    push_words(2, 32'hC100_0000);
    chk("R8", "tvalid before flush", 32'(m_tvalid), 1);
    wr(OFF_FLUSH, FLUSH_KEY);
    chk("R8", "tvalid after flush", 32'(m_tvalid), 0);
    rd(OFF_VAC, r);  chk("R8", "vacancy restored", r, USABLE);
    rd(OFF_STAT, r); chk("R8", "flush-complete bit", r, 32'h1 << BIT_RSTC);
    push_words(1, 32'hC200_0000);
    wr(OFF_LEN, 32'd4);
    drain("R8", 1, 32'hC200_0000, 8'hFF);

    // R11 back-to-back packets, R4 live vacancy
    wr(OFF_STAT, 32'hFFFF_FFFF);
    push_words(2, 32'hD000_0000);
    wr(OFF_LEN, 32'd8);
    push_words(3, 32'hD100_0000);
    wr(OFF_LEN, 32'd12);
    rd(OFF_VAC, r); chk("R4", "vacancy two packets", r, USABLE - 5);
    drain("R11", 2, 32'hD000_0000, 8'hFF);
    rd(OFF_VAC, r); chk("R4", "vacancy mid queue", r, USABLE - 3);
    chk("R11", "second packet waiting", 32'(m_tvalid), 1);
    drain("R11", 3, 32'hD100_0000, 8'h6D);

    // R10 write-one-to-clear
    rd(OFF_STAT, r); chk("R10", "tc set", r, 32'h1 << BIT_TC);
    wr(OFF_STAT, 32'h0);
    rd(OFF_STAT, r); chk("R10", "zero write keeps", r, 32'h1 << BIT_TC);
    wr(OFF_STAT, 32'h1 << BIT_TC);
    rd(OFF_STAT, r); chk("R10", "one write clears", r, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule